// File: doc/BRIEF.md
# Integer ALU with Condition Codes

A purely combinational 32-bit execute unit for a load/store processor pipeline. A 6-bit operation code picks one arithmetic, logic or shift function. The block applies it to two operands and returns the result. It also returns a fresh set of condition flags, a strobe telling the flag register to load them, and a marker for operation codes it does not implement. Operand muxing, register-file ports and memory paths sit outside the block.

The operation codes come in two banks. The lower bank computes a result only. The bank 0x10 higher computes the same result and also produces flags. Carry and overflow come from the sign bits of the two operands and the result, and the carry-in of the add-with-carry op is first folded into the second operand. Flags travel as a 4-bit vector ordered {N, Z, V, C}, with C in bit 0.

Top module: `int_alu_cc`

## Requirements
- R1: Codes 0x00 (add) and 0x04 (subtract) return a+b and a-b modulo 2^32. Codes 0x10 and 0x14 return the same results.
- R2: Codes 0x01, 0x02 and 0x03 return a AND b, a OR b and a XOR b. Codes 0x11, 0x12 and 0x13 return the same values.
- R3: Codes 0x05, 0x06 and 0x07 return a AND NOT b, a OR NOT b and a XOR NOT b. Codes 0x15, 0x16 and 0x17 return the same values.
- R4: Codes 0x08 and 0x18 first form b' = b + C_in, modulo 2^32, where C_in is flags_in bit 0. They then return a + b'.
- R5: Codes 0x10 through 0x18 drive flags_we high. Z (flags_out bit 2) is set exactly when the result is zero. N (bit 3) equals result bit 31.
- R6: For 0x10, V (bit 1) is set when a and b share a sign that the result lacks. C (bit 0) is the unsigned carry out of a+b. For 0x18 the same rules apply with b' in place of b. So b=0xFFFFFFFF with C_in=1 yields C=0.
- R7: For 0x14, V is set when a and b differ in sign and the result's sign differs from a. C is set when a is below b as unsigned numbers (a borrow).
- R8: Codes 0x11, 0x12, 0x13, 0x15, 0x16 and 0x17 clear both V and C.
- R9: Codes 0x25, 0x26 and 0x27 shift a left logically, right logically and right arithmetically. The shift amount is b[4:0]. The arithmetic form fills the vacated bits with a[31].
- R10: Codes 0x00 to 0x08 and the shifts drive flags_we low, drive illegal low, and copy flags_in to flags_out.
- R11: Every other code drives illegal high, result zero and flags_we low, and copies flags_in to flags_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand (register or extended immediate) |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,V,C} |
| flags_we | output | 1 | Load strobe for the flag register |
| illegal | output | 1 | Operation code not implemented |

## Verification
The hardest case to reach is the add-with-carry op with the second operand all ones and the carry-in set. Here b' wraps to zero, so the reported carry is 0 even though the three-input sum overflowed. The bench drives exactly that operand pair with flags_in bit 0 set and checks C. It also drives nearby sign combinations so that V is seen both set and clear for the incremented operand. Subtract borrow gets the same treatment. The bench drives equal operands, a-below-b pairs and a pair whose signs differ and overflows.

// File: rtl/int_alu_cc.sv
module int_alu_cc #(
  parameter int W = 32
) (
  input  logic [5:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic         flags_we,
  output logic         illegal
);
  localparam int SHW = $clog2(W);
  localparam logic [5:0] OP_SLL = 6'h25;
  localparam logic [5:0] OP_SRL = 6'h26;
  localparam logic [5:0] OP_SRA = 6'h27;

  logic [3:0]   fn;
  logic         bank_lo, bank_cc, arith_ok, is_shift;
  logic [W-1:0] b_eff, r;
  logic         a_s, b_s, r_s, v_f, c_f;
  logic [SHW-1:0] sh;

  assign fn       = op[3:0];
  assign bank_lo  = (op[5:4] == 2'b00);
  assign bank_cc  = (op[5:4] == 2'b01);
  assign arith_ok = (bank_lo || bank_cc) && (fn <= 4'd8);
  assign is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  assign sh       = b[SHW-1:0];
  assign b_eff    = (fn == 4'd8) ? b + {{(W-1){1'b0}}, flags_in[0]} : b;

  always_comb begin
    r = '0;
    if (arith_ok) begin
      case (fn)
        4'd0:    r = a + b;
        4'd1:    r = a & b;
        4'd2:    r = a | b;
        4'd3:    r = a ^ b;
        4'd4:    r = a - b;
        4'd5:    r = a & ~b;
        4'd6:    r = a | ~b;
        4'd7:    r = a ^ ~b;
        default: r = a + b_eff;
      endcase
    end else if (op == OP_SLL) r = a << sh;
    else if (op == OP_SRL)     r = a >> sh;
    else if (op == OP_SRA)     r = W'($signed(a) >>> sh);
  end

  assign a_s = a[W-1];
  assign b_s = b_eff[W-1];
  assign r_s = r[W-1];

  always_comb begin
    v_f = 1'b0;
    c_f = 1'b0;
    if (fn == 4'd0 || fn == 4'd8) begin
      v_f = (a_s & b_s & ~r_s) | (~a_s & ~b_s & r_s);
      c_f = (a_s & b_s) | (~r_s & (a_s | b_s));
    end else if (fn == 4'd4) begin
      v_f = (a_s & ~b_s & ~r_s) | (~a_s & b_s & r_s);
      c_f = (~a_s & b_s) | (r_s & (~a_s | b_s));
    end
  end

  assign result    = r;
  assign illegal   = !(arith_ok || is_shift);
  assign flags_we  = bank_cc && arith_ok;
  assign flags_out = flags_we ? {r_s, (r == '0), v_f, c_f} : flags_in;

  always_comb begin
    if (!$isunknown({op, a, b, flags_in})) begin
      assert_illegal_quiet_R11: assert (!illegal || (result == '0 && !flags_we && flags_out == flags_in))
        else $error("illegal op produced output");
      assert_hold_flags_R10: assert (flags_we || flags_out == flags_in)
        else $error("flags changed without write");
      assert_zn_R5: assert (!flags_we || (flags_out[2] == (result == '0) && flags_out[3] == result[W-1]))
        else $error("Z/N mismatch");
      assert_logic_clear_R8: assert (!(flags_we && fn != 4'd0 && fn != 4'd4 && fn != 4'd8) || flags_out[1:0] == 2'b00)
        else $error("logic op left V/C set");
      assert_shift_noflags_R9: assert (!is_shift || (!flags_we && !illegal))
        else $error("shift wrote flags");
    end
  end
endmodule

// File: tb/tb_int_alu_cc.sv
module tb_int_alu_cc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  fi = '0;
  logic [31:0] res;
  logic [3:0]  fo;
  logic        we, ill;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_cc dut (.op(op), .a(a), .b(b), .flags_in(fi), .result(res),
                  .flags_out(fo), .flags_we(we), .illegal(ill));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y, input logic [3:0] f);
    @(negedge clk);
    op = o; a = x; b = y; fi = f;
    #1;
  endtask

  // expected {N,Z,V,C} for a flag-setting op with result r
  function automatic logic [3:0] nz(input logic [31:0] r, input logic v, input logic c);
    return {r[31], (r == 32'd0), v, c};
  endfunction

  task automatic t_reset;
    chk("R10 idle result", res, 32'd0);
    chk("R10 idle we", {31'd0, we}, 32'd0);
    chk("R10 idle illegal", {31'd0, ill}, 32'd0);
  endtask

  task automatic t_add_sub;
    apply(6'h00, 32'h7FFF_FFFF, 32'h0000_0002, 4'hA);
    chk("R1 add", res, 32'h8000_0001);
    chk("R10 add flags pass", {28'd0, fo}, 32'hA);
    chk("R10 add we", {31'd0, we}, 32'd0);
    apply(6'h04, 32'h0000_0005, 32'h0000_0009, 4'h0);
    chk("R1 sub", res, 32'hFFFF_FFFC);
    apply(6'h10, 32'h1234_5678, 32'h1111_1111, 4'h0);
    chk("R1 addcc result", res, 32'h2345_6789);
  endtask

  task automatic t_logic;
    apply(6'h01, 32'hF0F0_1234, 32'hFF00_00FF, 4'h5);
    chk("R2 and", res, 32'hF000_0034);
    apply(6'h02, 32'hF0F0_1234, 32'h0F00_0001, 4'h5);
    chk("R2 or", res, 32'hFFF0_1235);
    apply(6'h13, 32'hAAAA_5555, 32'hFFFF_0000, 4'h0);
    chk("R2 xorcc result", res, 32'h5555_5555);
  endtask

  task automatic t_negated;
    apply(6'h05, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'h0);
    chk("R3 andn", res, 32'hF0F0_F0F0);
    apply(6'h06, 32'h0000_0001, 32'hFFFF_FF00, 4'h0);
    chk("R3 orn", res, 32'h0000_00FF);
    apply(6'h17, 32'h1234_5678, 32'h1234_5678, 4'h0);
    chk("R3 xnorcc result", res, 32'hFFFF_FFFF);
    chk("R8 xnorcc flags", {28'd0, fo}, {28'd0, nz(32'hFFFF_FFFF, 1'b0, 1'b0)});
  endtask

  task automatic t_addx;
    apply(6'h08, 32'h0000_0010, 32'h0000_0020, 4'h1);
    chk("R4 addx carry in", res, 32'h0000_0031);
    apply(6'h08, 32'h0000_0010, 32'h0000_0020, 4'hE);
    chk("R4 addx no carry", res, 32'h0000_0030);
    apply(6'h18, 32'h0000_0001, 32'hFFFF_FFFF, 4'h1);
    chk("R6 addxcc wrapped operand result", res, 32'h0000_0001);
    chk("R6 addxcc wrapped operand flags", {28'd0, fo}, {28'd0, nz(32'h1, 1'b0, 1'b0)});
    apply(6'h18, 32'h7FFF_FFFF, 32'h0000_0000, 4'h1);
    chk("R6 addxcc overflow", {28'd0, fo}, {28'd0, nz(32'h8000_0000, 1'b1, 1'b0)});
  endtask

  task automatic t_cc_flags;
    apply(6'h10, 32'hFFFF_FFFF, 32'h0000_0001, 4'h0);
    chk("R5 addcc we", {31'd0, we}, 32'd1);
    chk("R6 addcc zero carry", {28'd0, fo}, {28'd0, nz(32'h0, 1'b0, 1'b1)});
    apply(6'h10, 32'h8000_0000, 32'h8000_0000, 4'h0);
    chk("R6 addcc neg overflow", {28'd0, fo}, {28'd0, nz(32'h0, 1'b1, 1'b1)});
    apply(6'h14, 32'h0000_0003, 32'h0000_0003, 4'hF);
    chk("R7 subcc equal", {28'd0, fo}, {28'd0, nz(32'h0, 1'b0, 1'b0)});
    apply(6'h14, 32'h0000_0001, 32'h0000_0002, 4'h0);
    chk("R7 subcc borrow", {28'd0, fo}, {28'd0, nz(32'hFFFF_FFFF, 1'b0, 1'b1)});
    apply(6'h14, 32'h8000_0000, 32'h0000_0001, 4'h0);
    chk("R7 subcc overflow", {28'd0, fo}, {28'd0, nz(32'h7FFF_FFFF, 1'b1, 1'b0)});
  endtask

  task automatic t_logic_cc;
    apply(6'h11, 32'h8000_0000, 32'hFFFF_FFFF, 4'h3);
    chk("R8 andcc clears V C", {28'd0, fo}, {28'd0, nz(32'h8000_0000, 1'b0, 1'b0)});
    apply(6'h15, 32'h0000_00FF, 32'h0000_00FF, 4'h3);
    chk("R8 andncc zero", {28'd0, fo}, {28'd0, nz(32'h0, 1'b0, 1'b0)});
  endtask

  task automatic t_shifts;
    apply(6'h25, 32'h0000_0003, 32'hFFFF_FFE4, 4'h6);
    chk("R9 sll uses low 5 bits", res, 32'h0000_0030);
    chk("R9 sll flags pass", {28'd0, fo}, 32'h6);
    apply(6'h26, 32'h8000_0000, 32'h0000_001F, 4'h0);
    chk("R9 srl", res, 32'h0000_0001);
    apply(6'h27, 32'h8000_0000, 32'h0000_0004, 4'h0);
    chk("R9 sra sign fill", res, 32'hF800_0000);
    apply(6'h27, 32'h4000_0000, 32'h0000_0021, 4'h0);
    chk("R9 sra positive", res, 32'h2000_0000);
  endtask

  task automatic t_illegal;
    apply(6'h09, 32'h1, 32'h2, 4'h9);
    chk("R11 0x09 illegal", {31'd0, ill}, 32'd1);
    chk("R11 0x09 result", res, 32'd0);
    chk("R11 0x09 flags", {28'd0, fo}, 32'h9);
    apply(6'h19, 32'hFFFF_FFFF, 32'h1, 4'h4);
    chk("R11 0x19 we", {31'd0, we}, 32'd0);
    chk("R11 0x19 flags", {28'd0, fo}, 32'h4);
    apply(6'h24, 32'h5, 32'h1, 4'h0);
    chk("R11 0x24 illegal", {31'd0, ill}, 32'd1);
    apply(6'h3F, 32'h5, 32'h1, 4'h0);
    chk("R11 0x3F illegal", {31'd0, ill}, 32'd1);
  endtask

  initial begin
    #1;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_add_sub();
    t_logic();
    t_negated();
    t_addx();
    t_cc_flags();
    t_logic_cc();
    t_shifts();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule